// File: doc/BRIEF.md
# Packed SIMD Integer Adder

This block adds two packed integer vectors lane by lane. The lane size is picked for each operation from an opcode byte: the adder treats its operands as 8-bit, 16-bit or 32-bit lanes. A single operand-size prefix flag picks between a 128-bit operation and a 64-bit operation. Each lane wraps on overflow. No carry ever passes from one lane into the next, and the block raises no status flag. The same sum is correct for unsigned data and for two's-complement data.

An execution pipeline presents the destination operand, the source operand, the opcode byte and the prefix flag together with a valid strobe. The block returns the sum one clock later on its registered result port, with a valid pulse. The sum is meant to replace the destination operand. An opcode byte that is not an add code produces an illegal-opcode pulse in place of a result.

Top module: `simd_lane_adder`

## Requirements
- R1: Opcode byte 0xFC selects 8-bit lanes. Each result byte is (dst byte + src byte) mod 256.
- R2: Opcode byte 0xFD selects 16-bit lanes. Each result halfword (bits 16k+15:16k) is (dst + src) mod 65536.
- R3: Opcode byte 0xFE selects 32-bit lanes. Each result word (bits 32k+31:32k) is (dst + src) mod 2^32.
- R4: With in_wide_pfx = 1, all 128 bits are added. With in_wide_pfx = 0, only input bits 63:0 are used and result bits 127:64 are zero.
- R5: A carry never crosses a lane boundary, and the carry out of each lane is discarded. For example, all-ones plus a value of one in every lane gives zero in every lane.
- R6: When in_valid is high with a legal opcode, out_valid is high on the next clock edge for exactly one cycle, and out_result then holds the sum.
- R7: When in_valid is high with any other opcode byte, out_illegal is high on the next edge. In that cycle out_valid is low and out_result keeps its earlier value.
- R8: A synchronous active-high reset clears out_valid and out_illegal and sets out_result to zero.
- R9: A cycle with in_valid low leaves out_valid and out_illegal low on the next edge, and out_result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_opcode | input | 8 | Opcode byte (0xFC / 0xFD / 0xFE legal) |
| in_wide_pfx | input | 1 | Operand-size prefix: 1 = 128-bit, 0 = 64-bit |
| in_dst | input | 128 | Destination operand |
| in_src | input | 128 | Source operand |
| out_valid | output | 1 | Result valid pulse |
| out_illegal | output | 1 | Illegal-opcode pulse |
| out_result | output | 128 | Registered packed sum |

## Verification
Byte lanes get a near-exhaustive sweep: every value of one operand is paired with every third value of the other, and the lanes are skewed so that each byte position carries different data. This sets the wrapping of each lane apart from a carry leaking into its neighbour. Halfword and word lanes get random vectors and directed corner values: all-ones plus one, and the signed maximum plus one. These show whether the carry chain breaks at the 16-bit or 32-bit boundary and not at some other one. Narrow operations carry random upper input bits, which shows whether the upper half is ignored. A sweep over all 256 opcode bytes sets legal codes apart from illegal ones and checks that the result is held.

// File: rtl/sla_pkg.sv
`timescale 1ns/1ps
package sla_pkg;
  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_W16 = 2'd1,
    LANE_D32 = 2'd2
  } lane_sz_e;

  localparam logic [7:0] OPC_ADD_B = 8'hFC;
  localparam logic [7:0] OPC_ADD_W = 8'hFD;
  localparam logic [7:0] OPC_ADD_D = 8'hFE;

  // Bits of a unit index (mod 4) that must be non-zero for a carry to pass.
  function automatic logic [1:0] join_mask(lane_sz_e sz);
    case (sz)
      LANE_B8:  return 2'b00;
      LANE_W16: return 2'b01;
      default:  return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/sla_decode.sv
`timescale 1ns/1ps
module sla_decode
  import sla_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       wide_pfx,
  output logic       legal,
  output lane_sz_e   lane_sz,
  output logic       wide_op
);
  always_comb begin
    legal   = 1'b1;
    lane_sz = LANE_B8;
    case (opcode)
      OPC_ADD_B: lane_sz = LANE_B8;
      OPC_ADD_W: lane_sz = LANE_W16;
      OPC_ADD_D: lane_sz = LANE_D32;
      default:   legal   = 1'b0;
    endcase
  end

  assign wide_op = wide_pfx;
endmodule

// File: rtl/sla_lane_add.sv
`timescale 1ns/1ps
module sla_lane_add
  import sla_pkg::*;
#(
  parameter int UNIT_W    = 8,
  parameter int NUM_UNITS = 16
) (
  input  lane_sz_e                      lane_sz,
  input  logic                          wide_op,
  input  logic [UNIT_W*NUM_UNITS-1:0]   a,
  input  logic [UNIT_W*NUM_UNITS-1:0]   b,
  output logic [UNIT_W*NUM_UNITS-1:0]   sum
);
  localparam int HALF = NUM_UNITS / 2;

  logic [1:0]           jmask;
  logic [NUM_UNITS-1:0] carry;
  logic                 carry_top_unused;

  assign jmask            = join_mask(lane_sz);
  assign carry_top_unused = carry[NUM_UNITS-1];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic              cin;
    logic [UNIT_W:0]   part;

    if (u == 0) begin : g_first
      assign cin = 1'b0;
    end else begin : g_rest
      localparam logic [1:0] POS = 2'(u % 4);
      // carry passes only inside a lane: unit is not the first of its lane
      assign cin = carry[u-1] & ((POS & jmask) != 2'b00);
    end

    assign part = {1'b0, a[u*UNIT_W +: UNIT_W]}
                + {1'b0, b[u*UNIT_W +: UNIT_W]}
                + (UNIT_W+1)'(cin);
    assign carry[u] = part[UNIT_W];

    if (u >= HALF) begin : g_hi
      assign sum[u*UNIT_W +: UNIT_W] = wide_op ? part[UNIT_W-1:0] : '0;
    end else begin : g_lo
      assign sum[u*UNIT_W +: UNIT_W] = part[UNIT_W-1:0];
    end
  end
endmodule

// File: rtl/simd_lane_adder.sv
`timescale 1ns/1ps
module simd_lane_adder
  import sla_pkg::*;
#(
  parameter int UNIT_W    = 8,
  parameter int NUM_UNITS = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [7:0]                  in_opcode,
  input  logic                        in_wide_pfx,
  input  logic [UNIT_W*NUM_UNITS-1:0] in_dst,
  input  logic [UNIT_W*NUM_UNITS-1:0] in_src,
  output logic                        out_valid,
  output logic                        out_illegal,
  output logic [UNIT_W*NUM_UNITS-1:0] out_result
);
  localparam int W = UNIT_W * NUM_UNITS;

  logic       legal;
  lane_sz_e   lane_sz;
  logic       wide_op;
  logic [W-1:0] sum;

  sla_decode u_dec (
    .opcode   (in_opcode),
    .wide_pfx (in_wide_pfx),
    .legal    (legal),
    .lane_sz  (lane_sz),
    .wide_op  (wide_op)
  );

  sla_lane_add #(.UNIT_W(UNIT_W), .NUM_UNITS(NUM_UNITS)) u_add (
    .lane_sz (lane_sz),
    .wide_op (wide_op),
    .a       (in_dst),
    .b       (in_src),
    .sum     (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= in_valid & legal;
      out_illegal <= in_valid & ~legal;
      if (in_valid && legal) out_result <= sum;
    end
  end
endmodule

// File: rtl/sla_checker.sv
`timescale 1ns/1ps
module sla_checker
  import sla_pkg::*;
#(
  parameter int UNIT_W    = 8,
  parameter int NUM_UNITS = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic [7:0]                  in_opcode,
  input logic                        in_wide_pfx,
  input logic [UNIT_W*NUM_UNITS-1:0] in_dst,
  input logic [UNIT_W*NUM_UNITS-1:0] in_src,
  input logic                        out_valid,
  input logic                        out_illegal,
  input logic [UNIT_W*NUM_UNITS-1:0] out_result
);
  localparam int W = UNIT_W * NUM_UNITS;

  logic ok_opc;
  assign ok_opc = (in_opcode == OPC_ADD_B) || (in_opcode == OPC_ADD_W) ||
                  (in_opcode == OPC_ADD_D);

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    in_valid && ok_opc |=> out_valid && !out_illegal); // R6
  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid && !ok_opc |=> out_illegal && !out_valid && $stable(out_result)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !out_illegal && $stable(out_result)); // R9
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid && ok_opc && !in_wide_pfx |=> out_result[W-1:W/2] == '0); // R4
  AST_BYTE_LANE0: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_opcode == OPC_ADD_B |=>
      out_result[UNIT_W-1:0] == UNIT_W'($past(in_dst[UNIT_W-1:0]) + $past(in_src[UNIT_W-1:0]))); // R1
  AST_HALF_LANE0: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_opcode == OPC_ADD_W |=>
      out_result[2*UNIT_W-1:0] == (2*UNIT_W)'($past(in_dst[2*UNIT_W-1:0]) + $past(in_src[2*UNIT_W-1:0]))); // R2
  AST_WORD_LANE0: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_opcode == OPC_ADD_D |=>
      out_result[4*UNIT_W-1:0] == (4*UNIT_W)'($past(in_dst[4*UNIT_W-1:0]) + $past(in_src[4*UNIT_W-1:0]))); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_illegal)); // R7
endmodule

bind simd_lane_adder sla_checker #(.UNIT_W(UNIT_W), .NUM_UNITS(NUM_UNITS)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
  .in_wide_pfx(in_wide_pfx), .in_dst(in_dst), .in_src(in_src),
  .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result)
);

// File: tb/simd_lane_adder_tb.sv
`timescale 1ns/1ps
module simd_lane_adder_tb_top;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [7:0]   in_opcode = 8'h00;
  logic         in_wide_pfx = 1'b0;
  logic [W-1:0] in_dst = '0;
  logic [W-1:0] in_src = '0;
  logic         out_valid;
  logic         out_illegal;
  logic [W-1:0] out_result;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] held = '0;

  always #10 clk = ~clk;

  simd_lane_adder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_wide_pfx(in_wide_pfx), .in_dst(in_dst), .in_src(in_src),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result)
  );

  function automatic logic [W-1:0] ref_sum(int lane_bits, bit wide,
                                          logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r = '0;
    logic [W-1:0] m = (W'(1) << lane_bits) - W'(1);
    int total = wide ? W : W/2;
    for (int p = 0; p < total; p += lane_bits) begin
      logic [W-1:0] s = (((a >> p) & m) + ((b >> p) & m)) & m;
      r |= s << p;
    end
    return r;
  endfunction

  function automatic int bits_of(logic [7:0] opc);
    case (opc)
      8'hFC: return 8;
      8'hFD: return 16;
      8'hFE: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic logic [W-1:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] opc, bit wide, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = opc; in_wide_pfx = wide; in_dst = a; in_src = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // apply a legal op and check result + valid pulse
  task automatic run_legal(string tag, logic [7:0] opc, bit wide,
                           logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] e = ref_sum(bits_of(opc), wide, a, b);
    apply(opc, wide, a, b);
    chk(tag, out_result, e);
    chk({tag, " valid R6"}, W'(out_valid), W'(1));
    held = e;
  endtask

  task automatic idle_check(string tag);
    @(negedge clk);
    chk({tag, " R9 valid"}, W'({out_valid, out_illegal}), W'(0));
    chk({tag, " R9 hold"}, out_result, held);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset", {out_result[W-1:2], out_valid, out_illegal}, '0);
    rst = 1'b0;

    // R1 near-exhaustive byte sweep, skewed per byte position
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y += 3) begin
        logic [W-1:0] a, b;
        for (int k = 0; k < 16; k++) begin
          a[8*k +: 8] = 8'(x + 37*k);
          b[8*k +: 8] = 8'(y ^ (11*k));
        end
        run_legal("R1 byte", 8'hFC, 1'b1, a, b);
      end
    end

    // R2 / R3 random lanes
    for (int i = 0; i < 2500; i++) run_legal("R2 half", 8'hFD, 1'b1, rnd128(), rnd128());
    for (int i = 0; i < 2500; i++) run_legal("R3 word", 8'hFE, 1'b1, rnd128(), rnd128());

    // R5 lane isolation corners: all-ones + one per lane -> all zero
    run_legal("R5 byte", 8'hFC, 1'b1, '1, {16{8'h01}});
    chk("R5 byte zero", out_result, '0);
    run_legal("R5 half", 8'hFD, 1'b1, '1, {8{16'h0001}});
    chk("R5 half zero", out_result, '0);
    run_legal("R5 word", 8'hFE, 1'b1, '1, {4{32'h00000001}});
    chk("R5 word zero", out_result, '0);
    run_legal("R5 smax byte", 8'hFC, 1'b1, {16{8'h7F}}, {16{8'h01}});
    chk("R5 smax byte lit", out_result, {16{8'h80}});
    run_legal("R5 smax half", 8'hFD, 1'b1, {8{16'h7FFF}}, {8{16'h0001}});
    chk("R5 smax half lit", out_result, {8{16'h8000}});
    run_legal("R5 smax word", 8'hFE, 1'b1, {4{32'h7FFFFFFF}}, {4{32'h00000001}});
    chk("R5 smax word lit", out_result, {4{32'h80000000}});

    // R4 narrow mode with random upper input bits
    for (int i = 0; i < 600; i++) begin
      logic [7:0] opc = 8'hFC + 8'(i % 3);
      run_legal("R4 narrow", opc, 1'b0, rnd128(), rnd128());
      chk("R4 upper zero", {64'd0, out_result[127:64]}, '0);
    end

    // R6 / R7 / R9 sweep over all opcode bytes
    for (int o = 0; o < 256; o++) begin
      logic [W-1:0] a = rnd128();
      logic [W-1:0] b = rnd128();
      bit wide = bit'(o & 1);
      if (bits_of(8'(o)) != 0) begin
        run_legal("R6 opc", 8'(o), wide, a, b);
      end else begin
        apply(8'(o), wide, a, b);
        chk("R7 illegal", W'({out_illegal, out_valid}), W'(2));
        chk("R7 hold", out_result, held);
      end
      idle_check("opc");
    end

    // R8 reset mid-run
    run_legal("R8 pre", 8'hFE, 1'b1, '1, '1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R8 mid reset", {out_result[W-1:2], out_valid, out_illegal}, '0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule